// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupts

This block is a synchronous two-port memory whose two highest words double as message slots between the agents on its two sides, called side A and side B. Each side can read and write the whole array on its own. When one side writes the slot that belongs to the other side, that other side's interrupt goes active. The receiving side drops its interrupt by reading its own slot. Interrupt set and clear happen only as side effects of normal accesses, and the slots keep whatever data is written to them, like any other word.

The slot of side A sits at address DEPTH-2 and the slot of side B at DEPTH-1, where DEPTH is 2^ADDR_W. The slot positions therefore follow the depth parameter. A feature enable input turns the interrupt function off. While it is off, both slots act as plain storage.

Top module: `dpmb_top`

## Requirements
- R1: Once reset has been applied, `a_irq_n` and `b_irq_n` are 1 and `a_rdata` and `b_rdata` are 0.
- R2: A side writes `wdata` to `addr` on a clock edge where its `en` and `we` are both 1. A side whose `en` and `oe` are both 1 on an edge shows the word at `addr` on `rdata` after that edge. The word shown is the contents from before any write on that same edge. While a side is not reading, its `rdata` holds its value.
- R3: If both sides write the same address on the same edge, the word from side A is the one stored (default WINNER).
- R4: An edge where `mbx_en`=1 and side B writes address DEPTH-2 drives `a_irq_n` to 0 after that edge.
- R5: An edge where side A has `en`=1, `oe`=1 and `addr`=DEPTH-2 drives `a_irq_n` to 1 after that edge, for either value of its `we`.
- R6: An edge where `mbx_en`=1 and side A writes address DEPTH-1 drives `b_irq_n` to 0 after that edge.
- R7: An edge where side B has `en`=1, `oe`=1 and `addr`=DEPTH-1 drives `b_irq_n` to 1 after that edge.
- R8: If a setting write and a clearing read of the same slot fall on the same edge, the interrupt goes active or stays active.
- R9: An active interrupt stays active until its clearing access. A side that writes its own slot with `oe`=0 leaves its own interrupt as it was. Reads of other addresses also leave it unchanged.
- R10: While `mbx_en`=0, both interrupt outputs are 1 from the next edge on. Writes to the slots raise no interrupt, and they still store their data.
- R11: Either side can read back the data held in a slot, whichever side wrote it.
- R12: The slot addresses are computed from ADDR_W. Writes to DEPTH-3 raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| mbx_en | input | 1 | 1 turns the interrupt feature on |
| a_en | input | 1 | side A access enable |
| a_oe | input | 1 | side A read enable |
| a_we | input | 1 | side A write enable |
| a_addr | input | ADDR_W | side A address |
| a_wdata | input | DATA_W | side A write data |
| a_rdata | output | DATA_W | side A registered read data |
| a_irq_n | output | 1 | side A interrupt, active low |
| b_en | input | 1 | side B access enable |
| b_oe | input | 1 | side B read enable |
| b_we | input | 1 | side B write enable |
| b_addr | input | ADDR_W | side B address |
| b_wdata | input | DATA_W | side B write data |
| b_rdata | output | DATA_W | side B registered read data |
| b_irq_n | output | 1 | side B interrupt, active low |

## Verification
Each result of this block appears one edge after the access that causes it. That holds for read data, for an interrupt going active after the other side's write, for an interrupt going inactive after the owner's read, and for the forced clear when the feature enable drops. The driver applies each access half a period before an edge. It then queues the expected read words and interrupt levels, each tagged with the cycle number of that edge. The monitor compares every queued item at the falling edge that follows, so it samples each output one register stage after its cause and well away from the edge that updates it.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   // Mailbox slot owned by a side: DEPTH-2 for side A, DEPTH-1 for side B.
   function automatic int unsigned slot_addr(input int unsigned aw, input int unsigned side);
      return (32'd1 << aw) - 32'd2 + side;
   endfunction

endpackage

// File: rtl/dpmb_store.sv
module dpmb_store #(
   parameter int unsigned     DATA_W = 9,
   parameter int unsigned     ADDR_W = 6,
   parameter dpmb_pkg::side_e WINNER = dpmb_pkg::SIDE_A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_a,
   input  logic              wr_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] wdata_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic              rd_b,
   input  logic              wr_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] wdata_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              hit;
   logic              keep_a;
   logic              keep_b;

   assign hit = wr_a & wr_b & (addr_a == addr_b);

   // R3: the collision winner is picked at elaboration
   if (WINNER == dpmb_pkg::SIDE_A) begin : g_win_a
      assign keep_a = wr_a;
      assign keep_b = wr_b & ~hit;
   end else begin : g_win_b
      assign keep_a = wr_a & ~hit;
      assign keep_b = wr_b;
   end

   always_ff @(posedge clk) begin
      if (keep_a) mem[addr_a] <= wdata_a;
      if (keep_b) mem[addr_b] <= wdata_b;
   end

   // read-first registered read ports
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_a <= '0;
         rdata_b <= '0;
      end else begin
         if (rd_a) rdata_a <= mem[addr_a];
         if (rd_b) rdata_b <= mem[addr_b];
      end
   end

   a_r2_hold_a : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_a |=> $stable(rdata_a));
   a_r2_hold_b : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_b |=> $stable(rdata_b));
   a_r3_one_writer : assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (keep_a != keep_b));

endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic feat_en,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)        flag_o <= 1'b0;
      else if (!feat_en) flag_o <= 1'b0;
      else if (set_i)    flag_o <= 1'b1;
      else if (clr_i)    flag_o <= 1'b0;
   end

   a_r8_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (feat_en && set_i) |=> flag_o);
   a_r5_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (feat_en && clr_i && !set_i) |=> !flag_o);
   a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (feat_en && !set_i && !clr_i) |=> $stable(flag_o));
   a_r10_off : assert property (@(posedge clk) disable iff (!rst_n)
      !feat_en |=> !flag_o);

endmodule

// File: rtl/dpmb_top.sv
module dpmb_top #(
   parameter int unsigned     DATA_W = 9,
   parameter int unsigned     ADDR_W = 6,
   parameter dpmb_pkg::side_e WINNER = dpmb_pkg::SIDE_A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mbx_en,
   input  logic              a_en,
   input  logic              a_oe,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq_n,
   input  logic              b_en,
   input  logic              b_oe,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq_n
);
   localparam int unsigned NSIDE = 2;

   if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr
      $error("dpmb_top: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dpmb_top: DATA_W must be positive");
   end

   logic [NSIDE-1:0]  p_en, p_oe, p_we;
   logic [ADDR_W-1:0] p_addr [NSIDE];
   logic [NSIDE-1:0]  set_v, clr_v, flag_v;

   assign p_en = {b_en, a_en};
   assign p_oe = {b_oe, a_oe};
   assign p_we = {b_we, a_we};
   assign p_addr[0] = a_addr;
   assign p_addr[1] = b_addr;

   dpmb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WINNER(WINNER)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_a    (a_en & a_oe),
      .wr_a    (a_en & a_we),
      .addr_a  (a_addr),
      .wdata_a (a_wdata),
      .rdata_a (a_rdata),
      .rd_b    (b_en & b_oe),
      .wr_b    (b_en & b_we),
      .addr_b  (b_addr),
      .wdata_b (b_wdata),
      .rdata_b (b_rdata)
   );

   // R12: one slot decoder and flag per side, slot taken from ADDR_W
   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      localparam int unsigned       OTHER   = NSIDE - 1 - s;
      localparam logic [ADDR_W-1:0] MY_SLOT = ADDR_W'(dpmb_pkg::slot_addr(ADDR_W, s));

      assign set_v[s] = p_en[OTHER] & p_we[OTHER] & (p_addr[OTHER] == MY_SLOT);
      assign clr_v[s] = p_en[s] & p_oe[s] & (p_addr[s] == MY_SLOT);

      dpmb_flag u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .feat_en (mbx_en),
         .set_i   (set_v[s]),
         .clr_i   (clr_v[s]),
         .flag_o  (flag_v[s])
      );
   end

   assign a_irq_n = ~flag_v[0];
   assign b_irq_n = ~flag_v[1];

   a_r4_raise_a : assert property (@(posedge clk) disable iff (!rst_n)
      (mbx_en && b_en && b_we && (&b_addr[ADDR_W-1:1]) && !b_addr[0]) |=> !a_irq_n);
   a_r6_raise_b : assert property (@(posedge clk) disable iff (!rst_n)
      (mbx_en && a_en && a_we && (&a_addr)) |=> !b_irq_n);
   a_r7_clear_b : assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && b_oe && (&b_addr) && !(a_en && a_we && (&a_addr))) |=> b_irq_n);
   a_r9_own_write : assert property (@(posedge clk) disable iff (!rst_n)
      (mbx_en && a_en && a_we && !a_oe && (a_addr != ADDR_W'(dpmb_pkg::slot_addr(ADDR_W, 1)))
       && !(b_en && b_we)) |=> $stable(a_irq_n));

endmodule

// File: tb/dpmb_top_test.sv
`timescale 1ns/1ps
module dpmb_top_test;
   localparam int DW = 9;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;
   localparam logic [AW-1:0] SA = AW'(DEPTH - 2);
   localparam logic [AW-1:0] SB = AW'(DEPTH - 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mbx_en = 1'b1;
   logic a_en = 0, a_oe = 0, a_we = 0, b_en = 0, b_oe = 0, b_we = 0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic a_irq_n, b_irq_n;

   always #2 clk = ~clk;

   dpmb_top #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
      .a_en(a_en), .a_oe(a_oe), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_irq_n(a_irq_n),
      .b_en(b_en), .b_oe(b_oe), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_irq_n(b_irq_n)
   );

   typedef struct {
      int            due;
      int            kind;
      logic [DW-1:0] exp;
      string         tag;
   } item_t;

   item_t sb[$];
   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] ref_ra = '0, ref_rb = '0;
   bit fa = 0, fb = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: compares every item that is due at this falling edge
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         case (it.kind)
            0: check(it.tag, "a_rdata", a_rdata, it.exp);
            1: check(it.tag, "b_rdata", b_rdata, it.exp);
            2: check(it.tag, "a_irq_n", DW'(a_irq_n), it.exp);
            default: check(it.tag, "b_irq_n", DW'(b_irq_n), it.exp);
         endcase
      end
   end

   // driver: one access per side, then queue what must appear after the edge
   task automatic step(input logic ae, input logic aoe, input logic awe,
                       input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                       input logic be, input logic boe, input logic bwe,
                       input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
                       input string tag);
      bit sa, ca, sbb, cb;
      @(negedge clk);
      a_en = ae; a_oe = aoe; a_we = awe; a_addr = aad; a_wdata = awd;
      b_en = be; b_oe = boe; b_we = bwe; b_addr = bad; b_wdata = bwd;
      if (ae && aoe) ref_ra = ref_mem[aad];
      if (be && boe) ref_rb = ref_mem[bad];
      if (be && bwe) ref_mem[bad] = bwd;
      if (ae && awe) ref_mem[aad] = awd;
      sa  = be && bwe && (bad == SA);
      ca  = ae && aoe && (aad == SA);
      sbb = ae && awe && (aad == SB);
      cb  = be && boe && (bad == SB);
      if (!mbx_en) fa = 0; else if (sa) fa = 1; else if (ca) fa = 0;
      if (!mbx_en) fb = 0; else if (sbb) fb = 1; else if (cb) fb = 0;
      sb.push_back('{cyc + 1, 0, ref_ra, tag});
      sb.push_back('{cyc + 1, 1, ref_rb, tag});
      sb.push_back('{cyc + 1, 2, DW'(!fa), tag});
      sb.push_back('{cyc + 1, 3, DW'(!fb), tag});
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, '0, '0, 0, 0, 0, '0, '0, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "a_irq_n", DW'(a_irq_n), 9'd1);
      check("R1", "b_irq_n", DW'(b_irq_n), 9'd1);
      check("R1", "a_rdata", a_rdata, '0);
      check("R1", "b_rdata", b_rdata, '0);

      // R2 storage and read-first
      step(1, 0, 1, 6'd5, 9'h1A5, 0, 0, 0, '0, '0, "R2");
      step(0, 0, 0, '0, '0, 1, 1, 0, 6'd5, '0, "R2");
      step(0, 0, 0, '0, '0, 1, 0, 1, 6'd10, 9'h0F0, "R2");
      step(1, 1, 0, 6'd10, '0, 0, 0, 0, '0, '0, "R2");
      step(1, 1, 1, 6'd5, 9'h033, 0, 0, 0, '0, '0, "R2");
      step(1, 1, 0, 6'd5, '0, 0, 0, 0, '0, '0, "R2");
      idle("R2");
      // R3 collision
      step(1, 0, 1, 6'd20, 9'h111, 1, 0, 1, 6'd20, 9'h0EE, "R3");
      step(1, 1, 0, 6'd20, '0, 1, 1, 0, 6'd20, '0, "R3");
      // R4 raise A, R9 unrelated read keeps it, R11 read back, R5 clear
      step(0, 0, 0, '0, '0, 1, 0, 1, SA, 9'h155, "R4");
      step(1, 1, 0, 6'd5, '0, 0, 0, 0, '0, '0, "R9");
      step(0, 0, 0, '0, '0, 1, 1, 0, SA, '0, "R11");
      step(1, 1, 0, SA, '0, 0, 0, 0, '0, '0, "R5");
      // R6 raise B, R9 own-slot write, R7 clear
      step(1, 0, 1, SB, 9'h0AA, 0, 0, 0, '0, '0, "R6");
      step(0, 0, 0, '0, '0, 1, 0, 1, SB, 9'h0BB, "R9");
      step(1, 0, 1, SA, 9'h0CC, 0, 0, 0, '0, '0, "R9");
      step(0, 0, 0, '0, '0, 1, 1, 0, SB, '0, "R7");
      // R5 clear with write enable set
      step(0, 0, 0, '0, '0, 1, 0, 1, SA, 9'h066, "R5");
      step(1, 1, 1, SA, 9'h077, 0, 0, 0, '0, '0, "R5");
      step(0, 0, 0, '0, '0, 1, 1, 0, SA, '0, "R11");
      // R8 set beats clear, both sides
      step(1, 1, 0, SA, '0, 1, 0, 1, SA, 9'h101, "R8");
      step(1, 1, 1, SB, 9'h102, 1, 1, 0, SB, '0, "R8");
      step(1, 1, 0, SA, '0, 1, 1, 0, SB, '0, "R8");
      // R12 neighbour address
      step(1, 0, 1, AW'(DEPTH - 3), 9'h0D0, 1, 0, 1, AW'(DEPTH - 3), 9'h0D1, "R12");
      step(0, 0, 0, '0, '0, 1, 1, 0, AW'(DEPTH - 3), '0, "R12");
      // R10 disable forces inactive and blocks raising, data kept
      step(1, 0, 1, SB, 9'h1B0, 1, 0, 1, SA, 9'h1A0, "R10");
      @(negedge clk); mbx_en = 1'b0;
      idle("R10");
      step(1, 0, 1, SB, 9'h1B1, 1, 0, 1, SA, 9'h1A1, "R10");
      step(1, 1, 0, SA, '0, 1, 1, 0, SB, '0, "R10");
      @(negedge clk); mbx_en = 1'b1;
      idle("R10");
      idle("R10");
      if (n_run < 12) begin
         n_fail++;
         $display("FAIL R1 too few checks: actual %0d expected 12", n_run);
      end
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule